// File: doc/BRIEF.md
# Programmable Counter Array Timer

This block is one shared up-counter that serves as the time base for a row of compare/capture channels. The counter steps on one of four sources chosen by software: two fixed divisions of the peripheral clock, a strobe from a neighbouring timer's overflow, or rising edges on an external count pin. It runs only while a run bit is set, and it can be loaded with any value through the register port.

Each channel holds a value as wide as the counter and has one input pin and one output pin. In capture mode, a chosen edge on the input pin copies the counter into the channel's value. As a compare timer, the channel flags when the counter steps onto its value. As a toggle output, it flags and also inverts its output pin on that step. In pulse-width mode, the channel compares the counter's low byte with a buffered compare byte, and that byte is taken from the channel's value each time the low byte wraps.

The channel events and the counter overflow each set a sticky flag. All the flags are combined into one interrupt line.

Top module: `pca_timer`

## Requirements
- R1: After reset, the count, all flags, the interrupt and all channel output pins are 0.
- R2: Control register at address 0 has bit 0 as the run bit and bits 2:1 as the source field. Source 0 advances the count once every 6 clock cycles and source 1 once every 2 cycles. Both are counted from the cycle in which run is written to 1 from a stopped state.
- R3: With source 2, each clock cycle in which the timer 0 overflow strobe is high advances the count by one. With source 3, each rising edge of the external count pin advances the count by one, and the timer 0 strobe has no effect.
- R4: While the run bit is 0 the count holds. A write to address 1 loads the count with the written data.
- R5: When the count steps from all ones it wraps to 0 and sets flag bit NUM_MOD (bit 5), the overflow flag.
- R6: Channel i has its value at address 8+i and its mode at address 16+i in bits 2:0. Mode 1 captures on a rising pin edge, mode 2 on a falling edge, and mode 3 on both. A capture copies the count into the value and sets flag bit i. An edge of the other polarity changes neither the value nor the flag.
- R7: Mode 4 sets flag bit i when the count steps onto the channel value, and leaves the channel output pin unchanged.
- R8: Mode 5 sets flag bit i and inverts the channel output pin when the count steps onto the channel value.
- R9: In mode 6 the channel output pin is low while count bits 7:0 are below the compare byte and high otherwise. The compare byte is reloaded from value bits 7:0 only when the low byte steps from 0xFF, so a new value takes effect only after that wrap. This mode sets no flag.
- R10: Flags stay set until a 1 is written to their bit at address 2. The interrupt is high whenever any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| t0_ovf | input | 1 | Timer 0 overflow strobe |
| ext_cnt | input | 1 | External count pin |
| mod_in | input | 5 | Channel input pins |
| mod_out | output | 5 | Channel output pins |
| count_o | output | 16 | Current count |
| mod_val_o | output | 80 | Channel values, channel i in bits 16i+15:16i |
| flags_o | output | 6 | Sticky flags, channels in bits 4:0, overflow in bit 5 |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: a 16-bit count, five channels, an 8-bit pulse-width byte, and prescaler divisions of 6 and 2. Loading the count near all ones puts the wrap and the overflow flag two strobes away. The 8-bit low byte puts a full pulse-width period, including its buffered reload, within a few hundred strobes. Five channels give each capture polarity, the compare timer and the toggle output a channel of their own, so these modes are checked side by side for interference.

// File: rtl/pca_pkg.sv
// Shared types and register addresses of the counter array timer.
// Assumes at most eight channels, so that the value and mode address windows do not overlap.
package pca_pkg;
    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        SRC_DIV_SLOW = 2'd0,
        SRC_DIV_FAST = 2'd1,
        SRC_T0       = 2'd2,
        SRC_EXT      = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        MODE_OFF    = 3'd0,
        MODE_CAP_R  = 3'd1,
        MODE_CAP_F  = 3'd2,
        MODE_CAP_RF = 3'd3,
        MODE_TIMER  = 3'd4,
        MODE_TOGGLE = 3'd5,
        MODE_PWM    = 3'd6
    } mode_e;

    localparam logic [ADDR_W-1:0] A_CTRL      = 5'd0;
    localparam logic [ADDR_W-1:0] A_COUNT     = 5'd1;
    localparam logic [ADDR_W-1:0] A_CLR       = 5'd2;
    localparam logic [ADDR_W-1:0] A_VAL_BASE  = 5'd8;
    localparam logic [ADDR_W-1:0] A_MODE_BASE = 5'd16;
endpackage

// File: rtl/pca_prescaler.sv
// Divides the peripheral clock into a slow tick and a fast tick.
// Assumes DIV_SLOW is a multiple of DIV_FAST. The phase restarts whenever run is low.
module pca_prescaler #(
    parameter int DIV_SLOW = 6,
    parameter int DIV_FAST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick_slow,
    output logic tick_fast
);
    localparam int PW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;

    logic [PW-1:0] phase;

    // Phase counter, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            phase <= '0;
        else if (phase == PW'(DIV_SLOW - 1))
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    // Tick decode from the phase.
    always_comb begin
        tick_slow = run && (phase == PW'(DIV_SLOW - 1));
        tick_fast = run && ((phase % PW'(DIV_FAST)) == PW'(DIV_FAST - 1));
    end
endmodule

// File: rtl/pca_timebase.sv
// Shared up-counter with source selection and a synchronizer for the external count pin.
// Assumes the timer 0 strobe is synchronous to clk. A load has priority over a step.
module pca_timebase
    import pca_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  src_e             src,
    input  logic             tick_slow,
    input  logic             tick_fast,
    input  logic             t0_ovf,
    input  logic             ext_cnt,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_next,
    output logic             adv,
    output logic             wrap
);
    logic [2:0] ext_sh;
    logic       ext_rise;
    logic       sel_tick;

    // Two-flop synchronizer plus one history stage for the external pin.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ext_sh <= '0;
        else
            ext_sh <= {ext_sh[1:0], ext_cnt};
    end

    // Source multiplexer and step decode.
    always_comb begin
        ext_rise = ext_sh[1] & ~ext_sh[2];
        case (src)
            SRC_DIV_SLOW: sel_tick = tick_slow;
            SRC_DIV_FAST: sel_tick = tick_fast;
            SRC_T0:       sel_tick = t0_ovf;
            SRC_EXT:      sel_tick = ext_rise;
            default:      sel_tick = 1'b0;
        endcase
        adv      = run && !load && sel_tick;
        cnt_next = cnt + 1'b1;
        wrap     = adv && (cnt == '1);
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (adv)
            cnt <= cnt_next;
    end
endmodule

// File: rtl/pca_channel.sv
// One compare/capture channel: edge capture, compare timer, toggle output or pulse width.
// Assumes cnt_next is the value the count takes when adv is high. A register write has priority over a capture.
module pca_channel
    import pca_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PWM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode,
    input  logic             pin_in,
    input  logic             val_we,
    input  logic [CNT_W-1:0] val_wd,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             adv,
    output logic [CNT_W-1:0] val,
    output logic             event_o,
    output logic             pin_out
);
    logic [2:0]       pin_sh;
    logic             rise, fall, cap_hit, match, tog;
    logic [PWM_W-1:0] pwm_cmp;

    // Input pin synchronizer with edge history.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_sh <= '0;
        else
            pin_sh <= {pin_sh[1:0], pin_in};
    end

    // Capture and match decode.
    always_comb begin
        rise    = pin_sh[1] & ~pin_sh[2];
        fall    = ~pin_sh[1] & pin_sh[2];
        cap_hit = ((mode == MODE_CAP_R)  && rise) ||
                  ((mode == MODE_CAP_F)  && fall) ||
                  ((mode == MODE_CAP_RF) && (rise || fall));
        match   = adv && (cnt_next == val) &&
                  ((mode == MODE_TIMER) || (mode == MODE_TOGGLE));
        event_o = cap_hit || match;
    end

    // Channel value register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val <= '0;
        else if (val_we)
            val <= val_wd;
        else if (cap_hit)
            val <= cnt;
    end

    // Toggle output state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tog <= 1'b0;
        else if (match && (mode == MODE_TOGGLE))
            tog <= ~tog;
    end

    // Buffered compare byte, reloaded when the low byte wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm_cmp <= '0;
        else if (adv && (cnt[PWM_W-1:0] == '1))
            pwm_cmp <= val[PWM_W-1:0];
    end

    // Output pin select.
    always_comb begin
        if (mode == MODE_PWM)
            pin_out = (cnt[PWM_W-1:0] >= pwm_cmp);
        else
            pin_out = tog;
    end
endmodule

// File: rtl/pca_timer.sv
// Top of the counter array timer: register decode, flag collection, one shared counter and NUM_MOD channels.
// Assumes single-cycle writes. A flag set and a clear of the same flag in one cycle leave the flag set.
module pca_timer
    import pca_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NUM_MOD  = 5,
    parameter int PWM_W    = 8,
    parameter int DIV_SLOW = 6,
    parameter int DIV_FAST = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [CNT_W-1:0]         wr_data,
    input  logic                     t0_ovf,
    input  logic                     ext_cnt,
    input  logic [NUM_MOD-1:0]       mod_in,
    output logic [NUM_MOD-1:0]       mod_out,
    output logic [CNT_W-1:0]         count_o,
    output logic [NUM_MOD*CNT_W-1:0] mod_val_o,
    output logic [NUM_MOD:0]         flags_o,
    output logic                     irq_o
);
    localparam int FW = NUM_MOD + 1;

    logic               run_q;
    src_e               src_q;
    mode_e              mode_q [NUM_MOD];
    logic [FW-1:0]      flags_q;
    logic [NUM_MOD-1:0] ev;
    logic               tick_slow, tick_fast, adv, wrap, cnt_load;
    logic [CNT_W-1:0]   cnt, cnt_next;
    logic [FW-1:0]      clr_mask;

    // Control and flag-clear write decode.
    always_comb begin
        cnt_load = wr_en && (wr_addr == A_COUNT);
        clr_mask = (wr_en && (wr_addr == A_CLR)) ? wr_data[FW-1:0] : '0;
    end

    // Run bit and source field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            src_q <= SRC_DIV_SLOW;
        end else if (wr_en && (wr_addr == A_CTRL)) begin
            run_q <= wr_data[0];
            src_q <= src_e'(wr_data[2:1]);
        end
    end

    // Channel mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_MOD; i++) mode_q[i] <= MODE_OFF;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_MOD; i++)
                if (wr_addr == A_MODE_BASE + ADDR_W'(i))
                    mode_q[i] <= mode_e'(wr_data[2:0]);
        end
    end

    // Sticky flags: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= (flags_q & ~clr_mask) | {wrap, ev};
    end

    pca_prescaler #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_q),
        .tick_slow(tick_slow), .tick_fast(tick_fast)
    );

    pca_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(run_q), .src(src_q),
        .tick_slow(tick_slow), .tick_fast(tick_fast),
        .t0_ovf(t0_ovf), .ext_cnt(ext_cnt),
        .load(cnt_load), .load_val(wr_data),
        .cnt(cnt), .cnt_next(cnt_next), .adv(adv), .wrap(wrap)
    );

    for (genvar g = 0; g < NUM_MOD; g++) begin : g_ch
        logic val_we;
        assign val_we = wr_en && (wr_addr == A_VAL_BASE + ADDR_W'(g));
        pca_channel #(.CNT_W(CNT_W), .PWM_W(PWM_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .mode(mode_q[g]), .pin_in(mod_in[g]),
            .val_we(val_we), .val_wd(wr_data),
            .cnt(cnt), .cnt_next(cnt_next), .adv(adv),
            .val(mod_val_o[g*CNT_W +: CNT_W]), .event_o(ev[g]), .pin_out(mod_out[g])
        );
    end

    // Output drive.
    always_comb begin
        count_o = cnt;
        flags_o = flags_q;
        irq_o   = |flags_q;
    end
endmodule

// File: rtl/pca_timer_chk.sv
// Property checker for the counter array timer, bound to the top module.
// Assumes it observes the top's ports and the internal run bit.
module pca_timer_chk
    import pca_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_MOD = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [NUM_MOD:0]   clr_data,
    input logic [CNT_W-1:0]   count_o,
    input logic [NUM_MOD:0]   flags_o,
    input logic               run
);
    logic           cnt_wr;
    logic [NUM_MOD:0] clr;
    logic [NUM_MOD:0] kept;

    // Write qualifiers seen from outside.
    always_comb begin
        cnt_wr = wr_en && (wr_addr == A_COUNT);
        clr    = (wr_en && (wr_addr == A_CLR)) ? clr_data : '0;
        kept   = flags_o & ~clr;
    end

    // R2: without a load the count moves by at most one per cycle.
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> ((count_o == $past(count_o)) || (count_o == CNT_W'($past(count_o) + 1'b1))));

    // R4: a stopped counter holds unless loaded.
    a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(count_o));

    // R5: leaving all ones without a load means wrap with the overflow flag.
    a_r5_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_o == '1) && !cnt_wr) |=> ((count_o == '1) || ((count_o == '0) && flags_o[NUM_MOD])));

    // R10: flags not being cleared stay set.
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (kept != '0) |=> ((flags_o & $past(kept)) == $past(kept)));
endmodule

bind pca_timer pca_timer_chk #(.CNT_W(CNT_W), .NUM_MOD(NUM_MOD)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .clr_data(wr_data[NUM_MOD:0]), .count_o(count_o), .flags_o(flags_o), .run(run_q)
);

// File: tb/pca_timer_bench.sv
`timescale 1ns/1ps
module pca_timer_bench;
    localparam int CNT_W = 16;
    localparam int NM    = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic              t0_ovf = 1'b0;
    logic              ext_cnt = 1'b0;
    logic [NM-1:0]     mod_in = '0;
    logic [NM-1:0]     mod_out;
    logic [CNT_W-1:0]  count_o;
    logic [NM*CNT_W-1:0] mod_val_o;
    logic [NM:0]       flags_o;
    logic              irq_o;

    int checks = 0;
    int errors = 0;
    logic [CNT_W-1:0] held;

    // Vector: {source[1:0], cycles[15:0], expected count[15:0]}
    localparam logic [33:0] VEC [4] = '{
        {2'd0, 16'd60, 16'd10},
        {2'd1, 16'd60, 16'd30},
        {2'd0, 16'd13, 16'd2},
        {2'd1, 16'd5,  16'd2}
    };

    always #4 clk = ~clk;

    pca_timer u_pca_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .t0_ovf(t0_ovf), .ext_cnt(ext_cnt), .mod_in(mod_in), .mod_out(mod_out),
        .count_o(count_o), .mod_val_o(mod_val_o), .flags_o(flags_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_t0(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); t0_ovf = 1'b1;
            @(negedge clk); t0_ovf = 1'b0;
        end
    endtask

    task automatic pin(input int ch, input logic v);
        @(negedge clk); mod_in[ch] = v;
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [CNT_W-1:0] val_of(input int ch);
        return mod_val_o[ch*CNT_W +: CNT_W];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog actual=%h expected=%h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count", 32'(count_o), 0);
        chk("R1 flags", 32'(flags_o), 0);
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 pins", 32'(mod_out), 0);

        // R2: prescaled sources from the vector table
        for (int v = 0; v < 4; v++) begin
            wr(5'd0, 16'd0);
            wr(5'd1, 16'd0);
            wr(5'd0, {13'd0, VEC[v][33:32], 1'b1});
            repeat (int'(VEC[v][31:16])) @(negedge clk);
            chk("R2 prescaled count", 32'(count_o), 32'(VEC[v][15:0]));
        end

        // R4: stop holds, load writes
        wr(5'd0, 16'd0);
        held = count_o;
        repeat (20) @(negedge clk);
        chk("R4 hold while stopped", 32'(count_o), 32'(held));
        wr(5'd1, 16'h0ABC);
        chk("R4 load", 32'(count_o), 32'h0ABC);

        // R3: timer 0 strobe and external pin
        wr(5'd1, 16'd0);
        wr(5'd0, 16'd5);
        pulse_t0(9);
        chk("R3 timer0 source", 32'(count_o), 9);
        wr(5'd0, 16'd0);
        wr(5'd1, 16'd0);
        wr(5'd0, 16'd7);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk); ext_cnt = 1'b1;
            repeat (4) @(negedge clk); ext_cnt = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk("R3 external source", 32'(count_o), 7);
        pulse_t0(3);
        chk("R3 timer0 ignored in external mode", 32'(count_o), 7);

        // R5 and R10: wrap, overflow flag, sticky, clear
        wr(5'd0, 16'd0);
        wr(5'd1, 16'hFFFE);
        wr(5'd0, 16'd5);
        pulse_t0(1);
        chk("R5 before wrap flag", 32'(flags_o), 0);
        pulse_t0(1);
        chk("R5 wrap count", 32'(count_o), 0);
        chk("R5 overflow flag", 32'(flags_o), 32'h20);
        repeat (10) @(negedge clk);
        chk("R10 sticky flag", 32'(flags_o), 32'h20);
        chk("R10 irq", 32'(irq_o), 1);
        wr(5'd2, 16'h0020);
        chk("R10 cleared", 32'(flags_o), 0);
        chk("R10 irq low", 32'(irq_o), 0);

        // R6: captures
        wr(5'd0, 16'd0);
        wr(5'd1, 16'h1234);
        wr(5'd16, 16'd1);
        pin(0, 1'b1);
        chk("R6 rising capture value", 32'(val_of(0)), 32'h1234);
        chk("R6 rising capture flag", 32'(flags_o), 32'h01);
        wr(5'd2, 16'h003F);
        wr(5'd17, 16'd2);
        wr(5'd1, 16'h2222);
        pin(1, 1'b1);
        chk("R6 falling mode ignores rise value", 32'(val_of(1)), 0);
        chk("R6 falling mode ignores rise flag", 32'(flags_o), 0);
        pin(1, 1'b0);
        chk("R6 falling capture value", 32'(val_of(1)), 32'h2222);
        chk("R6 falling capture flag", 32'(flags_o), 32'h02);
        wr(5'd18, 16'd3);
        wr(5'd1, 16'h3333);
        pin(2, 1'b1);
        chk("R6 both edges rise", 32'(val_of(2)), 32'h3333);
        wr(5'd1, 16'h4444);
        pin(2, 1'b0);
        chk("R6 both edges fall", 32'(val_of(2)), 32'h4444);
        wr(5'd2, 16'h003F);

        // R7: compare timer on channel 3
        wr(5'd11, 16'd5);
        wr(5'd19, 16'd4);
        wr(5'd1, 16'd0);
        wr(5'd0, 16'd5);
        pulse_t0(4);
        chk("R7 no flag before match", 32'(flags_o), 0);
        pulse_t0(1);
        chk("R7 flag on match", 32'(flags_o), 32'h08);
        chk("R7 pin unchanged", 32'(mod_out[3]), 0);

        // R8: toggle output on channel 4
        wr(5'd12, 16'd8);
        wr(5'd20, 16'd5);
        pulse_t0(3);
        chk("R8 flag on match", 32'(flags_o[4]), 1);
        chk("R8 pin toggled high", 32'(mod_out[4]), 1);
        wr(5'd12, 16'd10);
        pulse_t0(2);
        chk("R8 pin toggled low", 32'(mod_out[4]), 0);
        wr(5'd2, 16'h003F);

        // R9: pulse width on channel 0
        wr(5'd8, 16'h0040);
        wr(5'd16, 16'd6);
        wr(5'd0, 16'd0);
        wr(5'd1, 16'h00FE);
        wr(5'd0, 16'd5);
        pulse_t0(2);
        chk("R9 low after reload", 32'(mod_out[0]), 0);
        pulse_t0(16'h3F);
        chk("R9 low below compare", 32'(mod_out[0]), 0);
        pulse_t0(1);
        chk("R9 high at compare", 32'(mod_out[0]), 1);
        wr(5'd8, 16'h0080);
        chk("R9 new value waits for wrap", 32'(mod_out[0]), 1);
        pulse_t0(16'hBF);
        chk("R9 high near end of period", 32'(mod_out[0]), 1);
        pulse_t0(1);
        chk("R9 count after period", 32'(count_o), 32'h0200);
        chk("R9 low after second reload", 32'(mod_out[0]), 0);
        pulse_t0(16'h80);
        chk("R9 high at new compare", 32'(mod_out[0]), 1);
        chk("R9 sets no flag", 32'(flags_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule